// File: doc/BRIEF.md
# Circular Message Queue Manager

This block keeps four circular lists of message frame addresses in a shared region of local memory and moves entries between those lists and a host. The lists hold free inbound frames, posted inbound frames, posted outbound frames and free outbound frames. Each list has a head pointer and a tail pointer. For every list the block advances one pointer, and a local processor writes the other.

The host reaches the lists through two ports. A read of a port pops the oldest entry of one list. A write to a port pushes an entry onto another list. For each access the block forms the memory address of the entry from a common base and the list's fixed slot, then performs a single word transfer on a request/acknowledge memory port. It also advances the pointer it owns. Only one access is in flight at a time, and any host access offered during that time is answered with retry. The block raises a host interrupt while posted outbound work is waiting. It raises a local doorbell when the host posts inbound work, and a local error when a host push fills the outbound free list.

Top module: `mfa_queue_mgr`

## Requirements
- R1: After reset, all eight pointers are 0. `host_irq`, `local_irq`, `local_err`, `host_retry`, `host_done` and `mem_req` are all 0.
- R2: Each list occupies SIZE = ENTRIES*4 bytes. An entry address is `qbase + k*SIZE + ptr`, where k is 0 for inbound free, 1 for inbound post, 2 for outbound post and 3 for outbound free. `mem_req` holds its address, data and direction stable until `mem_ack`.
- R3: A host read with `host_port`=0 pops the inbound free list. It returns the word at that list's tail, and the tail then advances by 4 modulo SIZE.
- R4: A host read of a list whose head equals its tail returns all ones. It makes no memory request and leaves the tail unchanged. This applies to both read ports.
- R5: A host write with `host_port`=0 stores the data at the inbound post head. The head advances by 4, and the doorbell flag (`local_irq`) is set.
- R6: A host read with `host_port`=1 pops the outbound post list in the same way as R3.
- R7: `host_irq` is 1 exactly while the outbound post head differs from its tail.
- R8: A host write with `host_port`=1 stores the data at the outbound free head and advances that head. If the advanced head equals the tail, the full flag (`local_err`) is set.
- R9: From the edge that accepts a host access until the edge that completes it, every offered host access gets `host_retry`=1 and is ignored. Completion happens after the memory transfer and the pointer advance.
- R10: A pulse on `cpu_ptr_we` loads `cpu_ptr_val` into the processor-owned pointer of list `cpu_ptr_sel`, with bits [1:0] forced to 0. The processor owns the inbound free head, the inbound post tail, the outbound post head and the outbound free tail.
- R11: `cpu_clr` bit 0 clears the doorbell flag and bit 1 clears the full flag. A 0 bit leaves its flag unchanged.
- R12: Every accepted host access ends with a one-cycle `host_done` pulse. For a read, `host_rdata` carries the result in that cycle.
- R13: `hw_ptr` shows the block-owned pointer of list k in bits [k*PTR_W +: PTR_W]. These are the tails of lists 0 and 2 and the heads of lists 1 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| qbase | input | ADDR_W | Base address of the four-list region |
| host_valid | input | 1 | Host access offered |
| host_we | input | 1 | 1 = push (write), 0 = pop (read) |
| host_port | input | 1 | 0 = inbound port, 1 = outbound port |
| host_wdata | input | DATA_W | Entry pushed by the host |
| host_retry | output | 1 | Offered access refused, must be repeated |
| host_done | output | 1 | Access completed |
| host_rdata | output | DATA_W | Popped entry, all ones when the list is empty |
| cpu_ptr_we | input | 1 | Processor pointer write strobe |
| cpu_ptr_sel | input | 2 | List whose processor-owned pointer is written |
| cpu_ptr_val | input | PTR_W | New byte offset |
| cpu_clr | input | 2 | Write-one-to-clear for doorbell (0) and full (1) flags |
| hw_ptr | output | 4*PTR_W | Block-owned pointers of all four lists |
| host_irq | output | 1 | Outbound post list not empty |
| local_irq | output | 1 | Doorbell flag |
| local_err | output | 1 | Outbound free list full flag |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory transfer done |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |

## Verification
The bench fills the outbound free list through sixteen host pushes. The flag must stay clear after the fifteenth push and set on the sixteenth, when the head wraps onto the tail. A comparison off by one slot would flag one push early or never. A stalled memory is used to offer a competing inbound pop in the middle of an outbound push. A pending free frame makes a wrongly accepted pop visible as a moved tail. Reads of empty lists must return all ones with no memory request. A processor head written with stray low bits must expose exactly one entry, not two. The doorbell and full flags are each cleared alone, so that a clear decoded onto the wrong bit shows up.

// File: rtl/mq_pkg.sv
package mq_pkg;
   // list index doubles as the slot number in the shared region
   typedef enum logic [1:0] {
      L_IN_FREE  = 2'd0,
      L_IN_POST  = 2'd1,
      L_OUT_POST = 2'd2,
      L_OUT_FREE = 2'd3
   } list_e;

   typedef enum logic {
      ST_IDLE   = 1'b0,
      ST_ACCESS = 1'b1
   } eng_state_e;

   // port 0 read/write -> lists 0/1, port 1 read/write -> lists 2/3
   function automatic list_e list_of(input logic port, input logic we);
      return list_e'({port, we});
   endfunction

   // lists whose head is advanced by the block (push targets)
   function automatic logic hw_owns_head(input int idx);
      return (idx == 1) || (idx == 3);
   endfunction
endpackage

// File: rtl/mq_ptr_bank.sv
module mq_ptr_bank #(
   parameter int PTR_W = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [3:0]                hw_inc,
   input  logic                      cpu_we,
   input  logic [1:0]                cpu_sel,
   input  logic [PTR_W-1:0]          cpu_val,
   output logic [3:0][PTR_W-1:0]     head_p,
   output logic [3:0][PTR_W-1:0]     tail_p,
   output logic [3:0][PTR_W-1:0]     hw_p
);
   localparam logic [PTR_W-1:0] STEP = PTR_W'(4);

   for (genvar g = 0; g < 4; g++) begin : g_list
      logic [PTR_W-1:0] hw_q;
      logic [PTR_W-1:0] sw_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         hw_q <= '0;
         else if (hw_inc[g]) hw_q <= hw_q + STEP;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sw_q <= '0;
         else if (cpu_we && (cpu_sel == 2'(g)))
            sw_q <= {cpu_val[PTR_W-1:2], 2'b00};
      end

      if (mq_pkg::hw_owns_head(g)) begin : g_push
         assign head_p[g] = hw_q;
         assign tail_p[g] = sw_q;
      end else begin : g_pop
         assign head_p[g] = sw_q;
         assign tail_p[g] = hw_q;
      end

      assign hw_p[g] = hw_q;
   end
endmodule

// File: rtl/mq_engine.sv
module mq_engine
   import mq_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int PTR_W  = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     qbase,
   input  logic                  host_valid,
   input  logic                  host_we,
   input  logic                  host_port,
   input  logic [DATA_W-1:0]     host_wdata,
   output logic                  host_retry,
   output logic                  host_done,
   output logic [DATA_W-1:0]     host_rdata,
   input  logic [3:0][PTR_W-1:0] head_p,
   input  logic [3:0][PTR_W-1:0] tail_p,
   output logic [3:0]            hw_inc,
   output logic                  evt_doorbell,
   output logic                  evt_full,
   output logic                  mem_req,
   output logic                  mem_we,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [DATA_W-1:0]     mem_wdata,
   input  logic                  mem_ack,
   input  logic [DATA_W-1:0]     mem_rdata
);
   localparam logic [PTR_W-1:0] STEP = PTR_W'(4);

   eng_state_e        state_q;
   list_e             op_q;
   list_e             req_list;
   logic [PTR_W-1:0]  req_ptr;
   logic              req_empty;
   logic              accept;
   logic              ack_now;
   logic [ADDR_W-1:0] req_addr;

   always_comb begin
      req_list  = list_of(host_port, host_we);
      req_ptr   = host_we ? head_p[req_list] : tail_p[req_list];
      req_empty = (head_p[req_list] == tail_p[req_list]);
      // slot size is a power of two, so slot*SIZE+ptr is a concatenation
      req_addr  = qbase + ADDR_W'({req_list, req_ptr});
   end

   assign accept     = host_valid && (state_q == ST_IDLE);
   assign ack_now    = (state_q == ST_ACCESS) && mem_ack;
   assign host_retry = host_valid && (state_q == ST_ACCESS);
   assign mem_req    = (state_q == ST_ACCESS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         op_q       <= L_IN_FREE;
         mem_we     <= 1'b0;
         mem_addr   <= '0;
         mem_wdata  <= '0;
         host_done  <= 1'b0;
         host_rdata <= '0;
      end else begin
         host_done <= 1'b0;
         if (accept) begin
            if (!host_we && req_empty) begin
               host_done  <= 1'b1;
               host_rdata <= '1;
            end else begin
               state_q   <= ST_ACCESS;
               op_q      <= req_list;
               mem_we    <= host_we;
               mem_addr  <= req_addr;
               mem_wdata <= host_wdata;
            end
         end else if (ack_now) begin
            state_q    <= ST_IDLE;
            host_done  <= 1'b1;
            host_rdata <= mem_we ? '0 : mem_rdata;
         end
      end
   end

   always_comb begin
      hw_inc = '0;
      if (ack_now) hw_inc[op_q] = 1'b1;
   end

   assign evt_doorbell = ack_now && (op_q == L_IN_POST);
   assign evt_full     = ack_now && (op_q == L_OUT_FREE) &&
                         ((head_p[L_OUT_FREE] + STEP) == tail_p[L_OUT_FREE]);
endmodule

// File: rtl/mq_status.sv
module mq_status #(
   parameter int NFLAGS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NFLAGS-1:0] set_ev,
   input  logic [NFLAGS-1:0] clr_w1c,
   output logic [NFLAGS-1:0] flags
);
   // a new event wins over a clear arriving in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~clr_w1c) | set_ev;
   end
endmodule

// File: rtl/mfa_queue_mgr.sv
module mfa_queue_mgr
   import mq_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int ENTRIES = 16,
   localparam int PTR_W  = $clog2(ENTRIES) + 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    qbase,
   input  logic                 host_valid,
   input  logic                 host_we,
   input  logic                 host_port,
   input  logic [DATA_W-1:0]    host_wdata,
   output logic                 host_retry,
   output logic                 host_done,
   output logic [DATA_W-1:0]    host_rdata,
   input  logic                 cpu_ptr_we,
   input  logic [1:0]           cpu_ptr_sel,
   input  logic [PTR_W-1:0]     cpu_ptr_val,
   input  logic [1:0]           cpu_clr,
   output logic [4*PTR_W-1:0]   hw_ptr,
   output logic                 host_irq,
   output logic                 local_irq,
   output logic                 local_err,
   output logic                 mem_req,
   output logic                 mem_we,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [DATA_W-1:0]    mem_wdata,
   input  logic                 mem_ack,
   input  logic [DATA_W-1:0]    mem_rdata
);
   localparam int SIZE_B = ENTRIES * 4;

   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("ENTRIES must be a power of two, at least 2");
   end
   if (ADDR_W < PTR_W + 2) begin : g_bad_addr
      $error("ADDR_W too narrow for four lists of %0d bytes", SIZE_B);
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("DATA_W must be at least 8");
   end

   logic [3:0][PTR_W-1:0] head_p;
   logic [3:0][PTR_W-1:0] tail_p;
   logic [3:0][PTR_W-1:0] hw_p;
   logic [3:0]            hw_inc;
   logic                  evt_doorbell;
   logic                  evt_full;
   logic [1:0]            flags;

   mq_ptr_bank #(.PTR_W(PTR_W)) i_ptrs (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_inc  (hw_inc),
      .cpu_we  (cpu_ptr_we),
      .cpu_sel (cpu_ptr_sel),
      .cpu_val (cpu_ptr_val),
      .head_p  (head_p),
      .tail_p  (tail_p),
      .hw_p    (hw_p)
   );

   mq_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W)) i_eng (
      .clk          (clk),
      .rst_n        (rst_n),
      .qbase        (qbase),
      .host_valid   (host_valid),
      .host_we      (host_we),
      .host_port    (host_port),
      .host_wdata   (host_wdata),
      .host_retry   (host_retry),
      .host_done    (host_done),
      .host_rdata   (host_rdata),
      .head_p       (head_p),
      .tail_p       (tail_p),
      .hw_inc       (hw_inc),
      .evt_doorbell (evt_doorbell),
      .evt_full     (evt_full),
      .mem_req      (mem_req),
      .mem_we       (mem_we),
      .mem_addr     (mem_addr),
      .mem_wdata    (mem_wdata),
      .mem_ack      (mem_ack),
      .mem_rdata    (mem_rdata)
   );

   mq_status #(.NFLAGS(2)) i_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_ev  ({evt_full, evt_doorbell}),
      .clr_w1c (cpu_clr),
      .flags   (flags)
   );

   assign hw_ptr    = hw_p;
   assign host_irq  = (head_p[L_OUT_POST] != tail_p[L_OUT_POST]);
   assign local_irq = flags[0];
   assign local_err = flags[1];
endmodule

// File: rtl/mq_checker.sv
module mq_checker #(
   parameter int ADDR_W = 32,
   parameter int SIZE_B = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] qbase,
   input logic              host_valid,
   input logic              host_retry,
   input logic              host_done,
   input logic              cpu_ptr_we,
   input logic              host_irq,
   input logic              local_irq,
   input logic              local_err,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr
);
   localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4 * SIZE_B);

   // R9: a refused access never coincides with a completion
   a_r9_retry_not_done: assert property (@(posedge clk) disable iff (!rst_n)
      host_retry |-> !host_done);

   // R9: retry is only given while a transfer is outstanding
   a_r9_retry_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
      host_retry |=> (mem_req || host_done));

   // R2: every transfer lands inside the four-list region
   a_r2_addr_window: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && $stable(qbase)) |-> ((mem_addr - qbase) < SPAN));

   // R2: request held steady until acknowledged
   a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R5: doorbell only follows a completed memory write
   a_r5_doorbell_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(local_irq) |-> $past(mem_req && mem_ack && mem_we));

   // R8: full flag only follows a completed memory write
   a_r8_full_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(local_err) |-> $past(mem_req && mem_ack && mem_we));

   // R7: outbound post becomes non-empty only by a processor head write
   a_r7_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_irq) |-> $past(cpu_ptr_we));

   // R7: it drains only by a pop or a processor pointer write
   a_r7_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(host_irq) |-> $past(mem_ack || cpu_ptr_we));

   // R12: a completion needs an accepted access or a memory acknowledge
   a_r12_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
      host_done |-> $past(mem_ack || host_valid));
endmodule

bind mfa_queue_mgr mq_checker #(.ADDR_W(ADDR_W), .SIZE_B(SIZE_B)) i_mq_checker (.*);

// File: tb/test_mfa_queue_mgr.sv
module test_mfa_queue_mgr;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int ADDR_W  = 32;
   localparam int DATA_W  = 32;
   localparam int ENTRIES = 16;
   localparam int PTR_W   = 6;
   localparam int SIZE_B  = 64;
   localparam logic [31:0] BASE = 32'h0000_4000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              host_valid = 1'b0;
   logic              host_we = 1'b0;
   logic              host_port = 1'b0;
   logic [31:0]       host_wdata = '0;
   logic              host_retry;
   logic              host_done;
   logic [31:0]       host_rdata;
   logic              cpu_ptr_we = 1'b0;
   logic [1:0]        cpu_ptr_sel = '0;
   logic [PTR_W-1:0]  cpu_ptr_val = '0;
   logic [1:0]        cpu_clr = '0;
   logic [4*PTR_W-1:0] hw_ptr;
   logic              host_irq, local_irq, local_err;
   logic              mem_req, mem_we;
   logic [31:0]       mem_addr, mem_wdata;
   logic              mem_ack = 1'b0;
   logic [31:0]       mem_rdata = '0;

   always #2 clk = ~clk;

   mfa_queue_mgr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRIES(ENTRIES)) i_mfa_queue_mgr (
      .clk(clk), .rst_n(rst_n), .qbase(BASE),
      .host_valid(host_valid), .host_we(host_we), .host_port(host_port),
      .host_wdata(host_wdata), .host_retry(host_retry), .host_done(host_done),
      .host_rdata(host_rdata), .cpu_ptr_we(cpu_ptr_we), .cpu_ptr_sel(cpu_ptr_sel),
      .cpu_ptr_val(cpu_ptr_val), .cpu_clr(cpu_clr), .hw_ptr(hw_ptr),
      .host_irq(host_irq), .local_irq(local_irq), .local_err(local_err),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit in_op = 1'b1;

   // behavioural memory with selectable latency
   logic [31:0] bmem [0:63];
   int          lat = 0;
   int          cnt = 0;
   int          n_mem = 0;
   logic [31:0] last_addr = '0;

   function automatic int widx(input logic [31:0] a);
      return int'((a - BASE) >> 2) & 63;
   endfunction

   always @(posedge clk) begin
      if (mem_ack) mem_ack <= 1'b0;
      else if (mem_req) begin
         if (cnt >= lat) begin
            mem_ack   <= 1'b1;
            cnt       <= 0;
            last_addr <= mem_addr;
            n_mem     <= n_mem + 1;
            if (mem_we) bmem[widx(mem_addr)] = mem_wdata;
            mem_rdata <= bmem[widx(mem_addr)];
         end else cnt <= cnt + 1;
      end
   end

   // reference model
   int          m_hw [4];
   int          m_sw [4];
   bit          m_door = 1'b0;
   bit          m_full = 1'b0;
   logic [31:0] q_free [$];
   logic [31:0] q_post [$];

   function automatic int m_head(input int l);
      return (l == 1 || l == 3) ? m_hw[l] : m_sw[l];
   endfunction
   function automatic int m_tail(input int l);
      return (l == 1 || l == 3) ? m_sw[l] : m_hw[l];
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // per-clock comparison against the model
   always begin
      @(negedge clk);
      #1;
      if (!in_op) begin
         for (int l = 0; l < 4; l++)
            chk(hw_ptr[l*PTR_W +: PTR_W] == PTR_W'(m_hw[l]), "R13 hw pointer",
                32'(hw_ptr[l*PTR_W +: PTR_W]), 32'(m_hw[l]));
         chk(host_irq == (m_head(2) != m_tail(2)), "R7 host_irq level", 32'(host_irq),
             32'(m_head(2) != m_tail(2)));
         chk(local_irq == m_door, "R5 doorbell flag", 32'(local_irq), 32'(m_door));
         chk(local_err == m_full, "R8 full flag", 32'(local_err), 32'(m_full));
         chk(host_retry == 1'b0, "R9 idle retry", 32'(host_retry), 0);
      end
   end

   task automatic host_op(input bit we, input bit port, input logic [31:0] wd, input bit poke,
                          output logic [31:0] rd, output bit used);
      int n0;
      int t;
      @(negedge clk);
      in_op = 1'b1;
      n0 = n_mem;
      host_valid = 1'b1; host_we = we; host_port = port; host_wdata = wd;
      @(negedge clk);
      host_valid = 1'b0;
      if (poke) begin
         host_valid = 1'b1; host_we = 1'b0; host_port = 1'b0;
         #1;
         chk(host_retry == 1'b1, "R9 retry during push", 32'(host_retry), 1);
         @(negedge clk);
         host_valid = 1'b0;
      end
      t = 0;
      while (!host_done && t < 60) begin
         @(negedge clk);
         t++;
      end
      chk(t < 60, "R12 completion pulse", 32'(t), 0);
      rd = host_rdata;
      used = (n_mem != n0);
   endtask

   task automatic do_pop(input bit port);
      int l;
      logic [31:0] rd;
      logic [31:0] exp;
      bit used;
      l = port ? 2 : 0;
      host_op(1'b0, port, '0, 1'b0, rd, used);
      if (m_head(l) == m_tail(l)) begin
         chk(rd == 32'hFFFF_FFFF, "R4 empty read value", rd, 32'hFFFF_FFFF);
         chk(!used, "R4 empty read no memory", 32'(used), 0);
      end else begin
         exp = port ? q_post.pop_front() : q_free.pop_front();
         chk(rd == exp, port ? "R6 outbound pop data" : "R3 inbound pop data", rd, exp);
         chk(last_addr == BASE + 32'(l * SIZE_B + m_hw[l]), "R2 pop address",
             last_addr, BASE + 32'(l * SIZE_B + m_hw[l]));
         m_hw[l] = (m_hw[l] + 4) & 63;
      end
      in_op = 1'b0;
   endtask

   task automatic do_push(input bit port, input logic [31:0] wd, input bit poke);
      int l;
      logic [31:0] rd;
      logic [31:0] ea;
      bit used;
      l = port ? 3 : 1;
      ea = BASE + 32'(l * SIZE_B + m_hw[l]);
      host_op(1'b1, port, wd, poke, rd, used);
      chk(last_addr == ea, "R2 push address", last_addr, ea);
      chk(bmem[widx(ea)] == wd, port ? "R8 outbound push data" : "R5 inbound push data",
          bmem[widx(ea)], wd);
      m_hw[l] = (m_hw[l] + 4) & 63;
      if (l == 1) m_door = 1'b1;
      if (l == 3 && m_hw[3] == m_tail(3)) m_full = 1'b1;
      in_op = 1'b0;
   endtask

   task automatic cpu_set(input int l, input int raw);
      @(negedge clk);
      in_op = 1'b1;
      cpu_ptr_we = 1'b1; cpu_ptr_sel = 2'(l); cpu_ptr_val = PTR_W'(raw);
      @(negedge clk);
      cpu_ptr_we = 1'b0;
      m_sw[l] = raw & 60;
      in_op = 1'b0;
   endtask

   // processor places an entry at its head and advances the head
   task automatic cpu_post(input int l, input logic [31:0] v, input int junk);
      bmem[widx(BASE + 32'(l * SIZE_B + m_sw[l]))] = v;
      if (l == 0) q_free.push_back(v); else q_post.push_back(v);
      cpu_set(l, ((m_sw[l] + 4) & 63) | junk);
   endtask

   task automatic cpu_clear(input logic [1:0] b);
      @(negedge clk);
      in_op = 1'b1;
      cpu_clr = b;
      @(negedge clk);
      cpu_clr = '0;
      if (b[0]) m_door = 1'b0;
      if (b[1]) m_full = 1'b0;
      in_op = 1'b0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      finish_run();
   end

   initial begin
      for (int i = 0; i < 64; i++) bmem[i] = 32'hDEAD_0000 | 32'(i);
      for (int i = 0; i < 4; i++) begin m_hw[i] = 0; m_sw[i] = 0; end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R1 reset state
      chk(hw_ptr == '0, "R1 pointers", 32'(hw_ptr), 0);
      chk(!host_irq && !local_irq && !local_err, "R1 interrupts",
          {29'd0, host_irq, local_irq, local_err}, 0);
      chk(!mem_req && !host_done && !host_retry, "R1 idle outputs",
          {29'd0, mem_req, host_done, host_retry}, 0);
      in_op = 1'b0;

      // R4 both read ports on empty lists
      do_pop(1'b0);
      do_pop(1'b1);

      // R3 / R10 inbound free list, second head write carries stray low bits
      cpu_post(0, 32'h0000_0100, 0);
      cpu_post(0, 32'h0000_0140, 3);
      cpu_post(0, 32'h0000_0180, 0);
      lat = 0; do_pop(1'b0);
      lat = 1; do_pop(1'b0);
      lat = 2; do_pop(1'b0);
      chk(hw_ptr[0 +: PTR_W] == PTR_W'(12), "R10 masked head exposes three entries",
          32'(hw_ptr[0 +: PTR_W]), 12);
      do_pop(1'b0);

      // R5 inbound post pushes raise the doorbell
      lat = 0;
      do_push(1'b0, 32'hA5A5_0001, 1'b0);
      do_push(1'b0, 32'hA5A5_0002, 1'b0);
      chk(local_irq == 1'b1, "R5 doorbell set", 32'(local_irq), 1);

      // R11 zero clear has no effect, bit 0 clears doorbell
      cpu_clear(2'b00);
      chk(local_irq == 1'b1, "R11 zero clear ignored", 32'(local_irq), 1);
      cpu_clear(2'b01);
      chk(local_irq == 1'b0, "R11 doorbell cleared", 32'(local_irq), 0);

      // R6 / R7 outbound post list
      chk(host_irq == 1'b0, "R7 empty outbound post", 32'(host_irq), 0);
      cpu_post(2, 32'hBEEF_0000, 0);
      chk(host_irq == 1'b1, "R7 irq on posted work", 32'(host_irq), 1);
      cpu_post(2, 32'hBEEF_0001, 0);
      do_pop(1'b1);
      chk(host_irq == 1'b1, "R7 irq while one left", 32'(host_irq), 1);
      do_pop(1'b1);
      chk(host_irq == 1'b0, "R7 irq drops when drained", 32'(host_irq), 0);
      do_pop(1'b1);

      // R9 competing pop during a stalled outbound push must be ignored
      cpu_post(0, 32'h0000_01C0, 0);
      lat = 3;
      do_push(1'b1, 32'hC0DE_0000, 1'b1);
      chk(hw_ptr[0 +: PTR_W] == PTR_W'(m_hw[0]), "R9 retried pop left tail",
          32'(hw_ptr[0 +: PTR_W]), 32'(m_hw[0]));
      lat = 0;
      do_pop(1'b0);

      // R8 fill the outbound free list: flag on the sixteenth push only
      for (int k = 1; k < 16; k++) begin
         do_push(1'b1, 32'hC0DE_0000 | 32'(k), 1'b0);
         if (k == 14) chk(local_err == 1'b0, "R8 not full after fifteen", 32'(local_err), 0);
      end
      chk(local_err == 1'b1, "R8 full after wrap", 32'(local_err), 1);

      // R11 clearing the doorbell leaves the full flag; bit 1 clears it
      cpu_clear(2'b01);
      chk(local_err == 1'b1, "R11 full kept", 32'(local_err), 1);
      cpu_clear(2'b10);
      chk(local_err == 1'b0, "R11 full cleared", 32'(local_err), 0);

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule